// File: doc/BRIEF.md
# Cell-Fed Cache Line Memory Server

This block answers cache line requests that arrive as fixed-length cells on a word-wide inbound stream. A CPU node sends one cell for each cache miss. The block reads the requested line from a synchronous single-port memory and returns it as one reply cell on the outbound stream. A request is either a plain fetch or a combined write-back-and-fetch. The combined form also carries the eight words of a dirty line that are to be stored before the fetch.

Write-back words go to memory in the cycle they arrive. The fetch therefore always starts at the same point, one cycle after the last request word, and both request kinds take the same time to serve. Cells flagged as interference traffic pass through the receiver and are thrown away. They touch neither memory nor the reply path. One request is served at a time. While a request is in progress, cells that begin are ignored in full.

Top module: `cms_mem_server`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, out_sop, mem_we and mem_re are low and rx_ready is high.
- R2: Every cell has 11 words and starts with in_sop. Word 0 is the header: bit 31 is the interference mark, bit 0 is the kind (0 = fetch, 1 = write-back-and-fetch) and bits 15:8 are the requester tag. Word 1 holds the fetch line, word 2 holds the write-back line, and words 3..10 carry line words 0..7. Line word k of line L lives at memory address L*8+k.
- R3: In a write-back-and-fetch cell, each of the eight data words is written to memory in the cycle it is received. It can be read back from memory before the next word arrives.
- R4: A fetch cell writes nothing to memory, whatever its words 2..10 contain.
- R5: The reply is 11 contiguous words with out_sop on the first. Word 0 holds the echoed tag in bits 15:8 and the kind in bit 0, with all other bits zero. Word 1 is the fetch line, zero-extended. Word 2 is zero. Words 3..10 are the fetch line's words 0..7 as they stand after any write-back in the same cell, so a write-back to the fetched line returns the new data.
- R6: The first reply word appears on the outputs two cycles after the cycle in which the last request word is taken. This delay is the same for both kinds.
- R7: A cell whose header has the interference mark set causes no memory write and no reply, and leaves rx_ready high. A request that follows it directly is served with the R6 timing.
- R8: rx_ready goes low in the cycle after an accepted header. It rises again in the cycle that the last reply word is on the outputs. A cell whose first word arrives while rx_ready is low is discarded in full: no writes and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound word present |
| in_sop | input | 1 | Inbound word is the first of a cell |
| in_data | input | 32 | Inbound cell word |
| rx_ready | output | 1 | High when a new request cell will be accepted |
| out_valid | output | 1 | Outbound word present |
| out_sop | output | 1 | Outbound word is the first of the reply |
| out_data | output | 32 | Outbound reply word |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data returned next cycle |
| mem_addr | output | 11 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_re |

## Verification
The bench sweeps sixteen line pairs with both request kinds and varied tags. This tells apart a wrong field position, a wrong address offset and a wrong header echo. Write-back-and-fetch cells aimed at their own fetch line separate writing the data as it arrives from reading the line before the write. Memory is inspected in the middle of each cell to show that each word is stored as it arrives. Interference cells, both alone and directly followed by a real request, together with a cell sent during a reply, show the difference between discarding and queueing. Every reply is timed to the cycle, which catches a turnaround that depends on the request kind.

// File: rtl/cms_pkg.sv
package cms_pkg;
  localparam int WORD_W       = 32;
  localparam int TAG_W        = 8;
  localparam int HDR_MARK_BIT = 31;
  localparam int HDR_KIND_BIT = 0;
  localparam int HDR_TAG_LSB  = 8;

  typedef enum logic {
    REQ_FETCH       = 1'b0,
    REQ_WBACK_FETCH = 1'b1
  } req_kind_e;

  function automatic logic [WORD_W-1:0] reply_header(input logic [TAG_W-1:0] tag,
                                                     input req_kind_e kind);
    logic [WORD_W-1:0] h;
    h = '0;
    h[HDR_TAG_LSB +: TAG_W] = tag;
    h[HDR_KIND_BIT] = kind;
    return h;
  endfunction

  function automatic logic is_marked(input logic [WORD_W-1:0] hdr);
    return hdr[HDR_MARK_BIT];
  endfunction
endpackage

// File: rtl/cms_rx.sv
module cms_rx
  import cms_pkg::*;
#(
  parameter int LINE_AW    = 8,
  parameter int LINE_WORDS = 8,
  parameter int HDR_WORDS  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  input  logic                                   in_sop,
  input  logic [WORD_W-1:0]                      in_data,
  input  logic                                   tx_finish,
  output logic                                   rx_ready,
  output logic                                   req_done,
  output req_kind_e                              req_kind,
  output logic [TAG_W-1:0]                       req_tag,
  output logic [LINE_AW-1:0]                     fetch_line,
  output logic                                   wr_en,
  output logic [LINE_AW+$clog2(LINE_WORDS)-1:0]  wr_addr,
  output logic [WORD_W-1:0]                      wr_data
);
  localparam int CELL_WORDS = HDR_WORDS + LINE_WORDS;
  localparam int IDX_W      = $clog2(CELL_WORDS);
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam logic [IDX_W-1:0] FETCH_IDX = IDX_W'(1);
  localparam logic [IDX_W-1:0] WBACK_IDX = IDX_W'(2);
  localparam logic [IDX_W-1:0] DATA0_IDX = IDX_W'(HDR_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_WORDS - 1);

  function automatic logic [OFF_W-1:0] line_offset(input logic [IDX_W-1:0] idx);
    return OFF_W'(idx - DATA0_IDX);
  endfunction

  logic               active_q, keep_q, busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [LINE_AW-1:0] wback_line_q;

  // Named events for the assertions and the write path
  logic accept_sop, body_word, payload_word;
  assign accept_sop   = in_valid && in_sop && !busy_q && !is_marked(in_data);
  assign body_word    = in_valid && !in_sop && active_q;
  assign payload_word = body_word && keep_q && (idx_q >= DATA0_IDX);

  assign rx_ready = !busy_q;
  assign req_done = body_word && keep_q && (idx_q == LAST_IDX);
  assign wr_en    = payload_word && (req_kind == REQ_WBACK_FETCH);
  assign wr_addr  = {wback_line_q, line_offset(idx_q)};
  assign wr_data  = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      keep_q       <= 1'b0;
      busy_q       <= 1'b0;
      idx_q        <= '0;
      req_kind     <= REQ_FETCH;
      req_tag      <= '0;
      fetch_line   <= '0;
      wback_line_q <= '0;
    end else begin
      if (in_valid && in_sop) begin
        active_q <= 1'b1;
        idx_q    <= FETCH_IDX;
        keep_q   <= accept_sop;
        if (accept_sop) begin
          busy_q   <= 1'b1;
          req_kind <= req_kind_e'(in_data[HDR_KIND_BIT]);
          req_tag  <= in_data[HDR_TAG_LSB +: TAG_W];
        end
      end else if (body_word) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) active_q <= 1'b0;
        if (keep_q && idx_q == FETCH_IDX) fetch_line   <= in_data[LINE_AW-1:0];
        if (keep_q && idx_q == WBACK_IDX) wback_line_q <= in_data[LINE_AW-1:0];
      end
      if (tx_finish) busy_q <= 1'b0;
    end
  end

  // R3: write-back words land at consecutive addresses as they arrive
  p_wr_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);

  // R7: a marked cell never takes the receiver out of the ready state
  p_mark_keeps_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sop && in_data[HDR_MARK_BIT] && rx_ready |=> rx_ready);

  // R8: a header taken while busy never leads to a write in the next cycle
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sop && !rx_ready |=> !wr_en);
endmodule

// File: rtl/cms_tx.sv
module cms_tx
  import cms_pkg::*;
#(
  parameter int LINE_AW    = 8,
  parameter int LINE_WORDS = 8,
  parameter int HDR_WORDS  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  req_kind_e                              req_kind,
  input  logic [TAG_W-1:0]                       req_tag,
  input  logic [LINE_AW-1:0]                     fetch_line,
  input  logic [WORD_W-1:0]                      mem_rdata,
  output logic                                   rd_en,
  output logic [LINE_AW+$clog2(LINE_WORDS)-1:0]  rd_addr,
  output logic                                   tx_finish,
  output logic                                   out_valid,
  output logic                                   out_sop,
  output logic [WORD_W-1:0]                      out_data
);
  localparam int CELL_WORDS = HDR_WORDS + LINE_WORDS;
  localparam int IDX_W      = $clog2(CELL_WORDS);
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam logic [IDX_W-1:0] FIRST_RD = IDX_W'(HDR_WORDS - 1);
  localparam logic [IDX_W-1:0] DATA0    = IDX_W'(HDR_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

  function automatic logic [OFF_W-1:0] read_offset(input logic [IDX_W-1:0] slot);
    return OFF_W'(slot - FIRST_RD);
  endfunction

  logic              running_q;
  logic [IDX_W-1:0]  slot_q;
  logic [WORD_W-1:0] word_nxt;

  assign rd_en     = running_q && (slot_q >= FIRST_RD) && (slot_q < LAST_IDX);
  assign rd_addr   = {fetch_line, read_offset(slot_q)};
  assign tx_finish = running_q && (slot_q == LAST_IDX);

  always_comb begin
    if (slot_q == '0)          word_nxt = reply_header(req_tag, req_kind);
    else if (slot_q == 1)      word_nxt = WORD_W'(fetch_line);
    else if (slot_q < DATA0)   word_nxt = '0;
    else                       word_nxt = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      slot_q    <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= running_q;
      out_sop   <= running_q && (slot_q == '0);
      out_data  <= running_q ? word_nxt : '0;
      if (start) begin
        running_q <= 1'b1;
        slot_q    <= '0;
      end else if (running_q) begin
        slot_q <= slot_q + 1'b1;
        if (tx_finish) running_q <= 1'b0;
      end
    end
  end

  // R5: line reads walk the fetch line word by word
  p_rd_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == $past(rd_addr) + 1'b1);

  // R5: the reply never stops before its last word
  p_reply_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(tx_finish) |=> out_valid);
endmodule

// File: rtl/cms_mem_server.sv
module cms_mem_server
  import cms_pkg::*;
#(
  parameter int LINE_AW    = 8,
  parameter int LINE_WORDS = 8,
  parameter int HDR_WORDS  = 3,
  localparam int MEM_AW    = LINE_AW + $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [WORD_W-1:0] in_data,
  output logic              rx_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic [WORD_W-1:0] out_data,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic               req_done, tx_finish, wr_en, rd_en;
  req_kind_e          req_kind;
  logic [TAG_W-1:0]   req_tag;
  logic [LINE_AW-1:0] fetch_line;
  logic [MEM_AW-1:0]  wr_addr, rd_addr;
  logic [WORD_W-1:0]  wr_data;

  cms_rx #(.LINE_AW(LINE_AW), .LINE_WORDS(LINE_WORDS), .HDR_WORDS(HDR_WORDS)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .tx_finish(tx_finish), .rx_ready(rx_ready), .req_done(req_done), .req_kind(req_kind),
    .req_tag(req_tag), .fetch_line(fetch_line), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  cms_tx #(.LINE_AW(LINE_AW), .LINE_WORDS(LINE_WORDS), .HDR_WORDS(HDR_WORDS)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(req_done), .req_kind(req_kind), .req_tag(req_tag),
    .fetch_line(fetch_line), .mem_rdata(mem_rdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .tx_finish(tx_finish), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data)
  );

  assign mem_we    = wr_en;
  assign mem_re    = rd_en;
  assign mem_addr  = rd_en ? rd_addr : wr_addr;
  assign mem_wdata = wr_data;

  // R3/R5: writes and reads never share the memory port
  p_port_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R6: reply header two cycles after the last request word
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> ##2 (out_valid && out_sop));

  // R8: ready returns only together with the final reply word
  p_ready_with_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> out_valid && !out_sop);

  // R1: outputs quiet while in reset
  always_comb begin
    if (!rst_n) p_reset_quiet_r1: assert (!mem_we && !mem_re);
  end
endmodule

// File: tb/test_cms_mem_server.sv
module test_cms_mem_server;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [31:0] in_data = '0;
  logic        rx_ready, out_valid, out_sop, mem_we, mem_re;
  logic [31:0] out_data, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [10:0] mem_addr;

  int vectors = 0, misses = 0;
  bit done = 0;

  logic [31:0] mem     [0:2047];
  logic [31:0] exp_mem [0:2047];

  always #10 clk = ~clk;

  cms_mem_server i_cms_mem_server (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .rx_ready(rx_ready), .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [31:0] seed_word(input logic [31:0] seed, input int k);
    return seed * 32'h0100_0193 ^ (32'(k) * 32'h1111_1111);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // Drives one 11-word cell; optionally leaves one idle cycle after it
  task automatic send_cell(input bit kind, input logic [7:0] tag, input int fetch, input int wb,
                           input bit marked, input bit accepted, input logic [31:0] seed,
                           input bit trail);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      // R3: the previous data word is already in memory
      if (accepted && kind && i >= 4)
        chk(mem[wb*8 + i - 4] == seed_word(seed, i - 4), "R3", mem[wb*8 + i - 4],
            seed_word(seed, i - 4));
      in_valid = 1'b1;
      in_sop   = (i == 0);
      case (i)
        0: in_data = {marked, 15'b0, tag, 7'b0, kind};
        1: in_data = 32'(fetch);
        2: in_data = 32'(wb);
        default: in_data = seed_word(seed, i - 3);
      endcase
    end
    if (accepted && kind)
      for (int k = 0; k < 8; k++) exp_mem[wb*8 + k] = seed_word(seed, k);
    if (trail) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
    end
  endtask

  // Called at the first negedge after the last request word
  task automatic check_reply(input bit kind, input logic [7:0] tag, input int fetch);
    logic [31:0] e;
    chk(!out_valid, "R6 early", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    chk(out_valid && out_sop, "R6 header timing", {30'b0, out_valid, out_sop}, 32'd3);
    chk(out_data == {16'b0, tag, 7'b0, kind}, "R5 header", out_data, {16'b0, tag, 7'b0, kind});
    chk(!rx_ready, "R8 busy", {31'b0, rx_ready}, 32'd0);
    for (int i = 1; i < 11; i++) begin
      @(negedge clk);
      e = (i == 1) ? 32'(fetch) : (i == 2) ? 32'd0 : exp_mem[fetch*8 + i - 3];
      chk(out_valid && !out_sop, "R5 contiguous", {30'b0, out_valid, out_sop}, 32'd2);
      chk(out_data == e, "R5 word", out_data, e);
      if (i == 9)  chk(!rx_ready, "R8 low before last", {31'b0, rx_ready}, 32'd0);
      if (i == 10) chk(rx_ready, "R8 ready with last", {31'b0, rx_ready}, 32'd1);
    end
    @(negedge clk);
    chk(!out_valid, "R5 end", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic check_silent(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!out_valid && rx_ready, req, {30'b0, out_valid, rx_ready}, 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 2048; a++) begin
      mem[a]     = 32'(a) * 32'h9E37_79B1 + 32'h0123_4567;
      exp_mem[a] = 32'(a) * 32'h9E37_79B1 + 32'h0123_4567;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && !out_sop, "R1 out", {30'b0, out_valid, out_sop}, 32'd0);
    chk(!mem_we && !mem_re, "R1 mem", {30'b0, mem_we, mem_re}, 32'd0);
    chk(rx_ready, "R1 ready", {31'b0, rx_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && rx_ready && !mem_we, "R1 after", {29'b0, out_valid, rx_ready, mem_we}, 32'd2);

    // R2/R4/R5/R6: sweep of line pairs, both kinds
    for (int l = 0; l < 16; l++) begin
      for (int k = 0; k < 2; k++) begin
        int f, w;
        f = (l * 37 + 5) % 256;
        w = (l * 11 + 100 + k) % 256;
        send_cell(k[0], 8'(l * 16 + k * 3 + 1), f, w, 1'b0, 1'b1, 32'(l * 2 + k + 77), 1'b1);
        check_reply(k[0], 8'(l * 16 + k * 3 + 1), f);
      end
    end
    // R3/R5: write-back into the fetched line returns the new data
    for (int l = 0; l < 4; l++) begin
      send_cell(1'b1, 8'(200 + l), 40 + l, 40 + l, 1'b0, 1'b1, 32'(900 + l), 1'b1);
      check_reply(1'b1, 8'(200 + l), 40 + l);
    end
    // R3/R4: read back every line touched by the sweep
    for (int l = 0; l < 16; l++) begin
      for (int k = 0; k < 2; k++) begin
        int w;
        w = (l * 11 + 100 + k) % 256;
        send_cell(1'b0, 8'(l), w, 0, 1'b0, 1'b1, 32'd5, 1'b1);
        check_reply(1'b0, 8'(l), w);
      end
    end
    // R7: marked cell alone: no reply, no write, ready stays high
    send_cell(1'b1, 8'h55, 60, 61, 1'b1, 1'b0, 32'hDEAD, 1'b1);
    check_silent(14, "R7 silent");
    send_cell(1'b0, 8'h56, 61, 0, 1'b0, 1'b1, 32'd1, 1'b1);
    check_reply(1'b0, 8'h56, 61);
    // R7: marked cell followed at once by a real request
    send_cell(1'b1, 8'h57, 62, 62, 1'b1, 1'b0, 32'hBEEF, 1'b0);
    send_cell(1'b1, 8'h58, 63, 62, 1'b0, 1'b1, 32'd333, 1'b1);
    check_reply(1'b1, 8'h58, 63);
    send_cell(1'b0, 8'h59, 62, 0, 1'b0, 1'b1, 32'd2, 1'b1);
    check_reply(1'b0, 8'h59, 62);
    // R8: a cell sent during a reply is dropped in full
    send_cell(1'b0, 8'h60, 70, 0, 1'b0, 1'b1, 32'd3, 1'b1);
    fork
      check_reply(1'b0, 8'h60, 70);
      send_cell(1'b1, 8'h61, 71, 72, 1'b0, 1'b0, 32'h7777, 1'b1);
    join
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      chk(!out_valid, "R8 no second reply", {31'b0, out_valid}, 32'd0);
    end
    send_cell(1'b0, 8'h62, 72, 0, 1'b0, 1'b1, 32'd4, 1'b1);
    check_reply(1'b0, 8'h62, 72);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule